// File: doc/BRIEF.md
# Ring Occupancy Doorbell Controller

This block keeps the runtime state of a small set of hardware work rings. Software produces fixed-size elements and a hardware engine consumes them. For each ring the block holds three values: an element count, a sticky flag that reports that a teardown has finished, and a write index. Each ring also has a size value that software can change. A producer reports pushed and popped elements by writing a signed count to the ring's doorbell. The count may make the element counter wrap past zero in either direction. Firmware uses this wrap on purpose to flush a count that has become stuck.

Every ring has its own 4 KiB register window. The access port is a plain valid/ready request bus that is always ready. A read response arrives one cycle after the request is taken. The engine side raises one teardown-done line per ring. A write to a ring's clear register puts that ring back to empty, and the size value is kept.

Top module: `ringdb_ctrl`

## Requirements
- R1: After reset, every ring reads an occupancy of 0, a clear teardown flag, a write index of 0 and a size of 0, and `rsp_valid` is low.
- R2: `rsp_valid` is high in the cycle after each accepted read and only then. Writes produce no response.
- R3: A read of offset 0x18 returns the 21-bit count in bits 20:0 and the teardown flag in bit 31. Bits 30:21 read as zero.
- R4: A write to offset 0x10 (doorbell) adds bits 7:0 of the data, taken as two's complement (0x01 is +1, 0xFF is -1, 0x80 is -128), to the count. Bits 31:8 are ignored. A count of zero leaves the state unchanged.
- R5: The count wraps modulo 2^21. Going below zero from 0 gives 0x1FFFFF, and going past 0x1FFFFF gives small values.
- R6: A doorbell with a positive count n moves the write index (offset 0x1C) to (index + n) mod size. A zero or negative count, or a size of 0, leaves the index unchanged.
- R7: Ring k's window starts at byte address k*0x1000, and the ring is chosen by address bits above bit 11. An access changes only the ring it addresses.
- R8: A pulse on `tdown_done[k]` sets ring k's teardown flag. The flag stays set through doorbell traffic until a clear.
- R9: A write of any data to offset 0x2C clears that ring's count, write index and teardown flag, and keeps its size. If a clear and a teardown pulse reach the same ring in the same cycle, the clear wins.
- R10: Writes to offsets other than 0x10, 0x28 and 0x2C have no effect. Reads of offsets other than 0x18, 0x1C and 0x28 return 0.
- R11: Offset 0x28 holds the ring size. A write stores data bits IDX_W-1:0, and a read returns that value zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address: ring number above bit 11, register offset in bits 11:0 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| tdown_done | input | NUM_RINGS | Per-ring teardown-complete pulses |

## Verification
The assertions check the following on every cycle:
- The response timing follows read acceptance.
- The decoder selects at most one ring.
- The count holds when there is no doorbell.
- A clear empties the ring on the next cycle.
- The teardown flag is sticky.
- The write index stays below the size after a positive step.

The arithmetic itself can only be shown by the bench scenarios, because it needs a reference to compare against:
- the signed sum with its wrap in both directions,
- the modulo step of the index, including small sizes,
- the register format,
- isolation between rings,
- the silence of unmapped offsets.

// File: rtl/ringdb_pkg.sv
package ringdb_pkg;
    localparam int OCC_W  = 21;
    localparam int CNT_W  = 8;
    localparam int WIN_W  = 12;
    localparam int DATA_W = 32;

    localparam logic [WIN_W-1:0] OFS_DOORBELL = 12'h010;
    localparam logic [WIN_W-1:0] OFS_COUNT    = 12'h018;
    localparam logic [WIN_W-1:0] OFS_WINDEX   = 12'h01C;
    localparam logic [WIN_W-1:0] OFS_SIZE     = 12'h028;
    localparam logic [WIN_W-1:0] OFS_CLEAR    = 12'h02C;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_DOORBELL,
        RK_COUNT,
        RK_WINDEX,
        RK_SIZE,
        RK_CLEAR
    } reg_kind_e;
endpackage

// File: rtl/ringdb_decode.sv
module ringdb_decode
    import ringdb_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int RING_BITS = 2,
    parameter int ADDR_W    = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    output reg_kind_e            kind,
    output logic [NUM_RINGS-1:0] sel,
    output logic [RING_BITS-1:0] ring_idx
);
    logic [WIN_W-1:0] ofs;
    logic             in_range;

    always_comb begin
        ring_idx = addr[ADDR_W-1:WIN_W];
        ofs      = addr[WIN_W-1:0];
        in_range = (int'(ring_idx) < NUM_RINGS);
        sel      = in_range ? (NUM_RINGS'(1) << ring_idx) : '0;
        kind     = RK_NONE;
        if (in_range) begin
            case (ofs)
                OFS_DOORBELL: kind = RK_DOORBELL;
                OFS_COUNT:    kind = RK_COUNT;
                OFS_WINDEX:   kind = RK_WINDEX;
                OFS_SIZE:     kind = RK_SIZE;
                OFS_CLEAR:    kind = RK_CLEAR;
                default:      kind = RK_NONE;
            endcase
        end
    end

    // R7: at most one ring window is addressed
    p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/ringdb_slot.sv
module ringdb_slot
    import ringdb_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             db_we,
    input  logic [CNT_W-1:0] db_cnt,
    input  logic             size_we,
    input  logic [IDX_W-1:0] size_val,
    input  logic             clr,
    input  logic             td_set,
    output logic [OCC_W-1:0] occ,
    output logic             td,
    output logic [IDX_W-1:0] widx,
    output logic [IDX_W-1:0] size
);
    typedef struct packed {
        logic [OCC_W-1:0] occ;
        logic             td;
        logic [IDX_W-1:0] widx;
        logic [IDX_W-1:0] size;
    } slot_t;

    slot_t st_d, st_q;
    logic [OCC_W-1:0] cnt_ext;
    logic             cnt_pos;
    logic [IDX_W:0]   idx_sum;
    logic [IDX_W:0]   idx_mod;

    always_comb begin
        st_d    = st_q;
        cnt_ext = {{(OCC_W-CNT_W){db_cnt[CNT_W-1]}}, db_cnt};
        cnt_pos = !db_cnt[CNT_W-1] && (db_cnt != '0);
        idx_sum = {1'b0, st_q.widx} + (IDX_W+1)'(db_cnt[CNT_W-2:0]);
        idx_mod = (st_q.size != '0) ? (idx_sum % {1'b0, st_q.size}) : '0;
        if (td_set)
            st_d.td = 1'b1;
        if (db_we) begin
            st_d.occ = st_q.occ + cnt_ext;
            if (cnt_pos && st_q.size != '0)
                st_d.widx = idx_mod[IDX_W-1:0];
        end
        if (size_we)
            st_d.size = size_val;
        if (clr) begin
            st_d.occ  = '0;
            st_d.widx = '0;
            st_d.td   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign occ  = st_q.occ;
    assign td   = st_q.td;
    assign widx = st_q.widx;
    assign size = st_q.size;

    // R4: count holds without a doorbell or clear
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!db_we && !clr) |=> $stable(occ));
    // R9: clear empties the ring
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (occ == '0 && widx == '0 && !td));
    // R8: teardown flag is sticky until clear
    p_td_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (td && !clr) |=> td);
    // R8: pulse sets the flag when no clear competes
    p_td_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (td_set && !clr) |=> td);
    // R6: positive step keeps index below size
    p_widx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (db_we && !db_cnt[CNT_W-1] && db_cnt != '0 && size != '0 && !clr && !size_we)
        |=> (widx < size));
endmodule

// File: rtl/ringdb_ctrl.sv
module ringdb_ctrl
    import ringdb_pkg::*;
#(
    parameter int NUM_RINGS = 4,
    parameter int IDX_W     = 16,
    localparam int RING_BITS = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1,
    localparam int ADDR_W    = RING_BITS + WIN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [NUM_RINGS-1:0] tdown_done
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    reg_kind_e            kind;
    logic [NUM_RINGS-1:0] sel;
    logic [RING_BITS-1:0] ring_idx;
    logic                 wr_fire;
    logic                 rd_fire;

    logic [OCC_W-1:0] occ_a  [NUM_RINGS];
    logic             td_a   [NUM_RINGS];
    logic [IDX_W-1:0] widx_a [NUM_RINGS];
    logic [IDX_W-1:0] size_a [NUM_RINGS];

    rsp_t rsp_d, rsp_q;

    assign req_ready = 1'b1;
    assign wr_fire   = req_valid && req_write;
    assign rd_fire   = req_valid && !req_write;

    ringdb_decode #(
        .NUM_RINGS(NUM_RINGS),
        .RING_BITS(RING_BITS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (req_addr),
        .kind    (kind),
        .sel     (sel),
        .ring_idx(ring_idx)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        ringdb_slot #(.IDX_W(IDX_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .db_we   (wr_fire && sel[g] && kind == RK_DOORBELL),
            .db_cnt  (req_wdata[CNT_W-1:0]),
            .size_we (wr_fire && sel[g] && kind == RK_SIZE),
            .size_val(req_wdata[IDX_W-1:0]),
            .clr     (wr_fire && sel[g] && kind == RK_CLEAR),
            .td_set  (tdown_done[g]),
            .occ     (occ_a[g]),
            .td      (td_a[g]),
            .widx    (widx_a[g]),
            .size    (size_a[g])
        );
    end

    always_comb begin
        rsp_d.valid = rd_fire;
        rsp_d.data  = '0;
        for (int i = 0; i < NUM_RINGS; i++) begin
            if (sel[i]) begin
                case (kind)
                    RK_COUNT:  rsp_d.data = {td_a[i], {(DATA_W-1-OCC_W){1'b0}}, occ_a[i]};
                    RK_WINDEX: rsp_d.data = DATA_W'(widx_a[i]);
                    RK_SIZE:   rsp_d.data = DATA_W'(size_a[i]);
                    default:   rsp_d.data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    // R2: a response follows each accepted read
    p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    // R2: no response without a read
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: tb/sim_ringdb_ctrl.sv
module sim_ringdb_ctrl;
    localparam int N     = 4;
    localparam int IDX_W = 16;
    localparam int AW    = 14;
    localparam int MODV  = 1 << 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [N-1:0]  tdown_done = '0;

    int total = 0;
    int bad   = 0;

    int m_occ [N];
    int m_widx[N];
    int m_size[N];
    bit m_td  [N];

    bit          pend = 0;
    logic [31:0] pend_data = '0;
    string       pend_tag = "";
    bit          exp_valid = 0;
    logic [31:0] exp_data = '0;
    string       exp_tag = "";

    always #4 clk = ~clk;

    ringdb_ctrl #(.NUM_RINGS(N), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tdown_done(tdown_done)
    );

    always @(posedge clk) begin
        exp_valid <= pend;
        exp_data  <= pend_data;
        exp_tag   <= pend_tag;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (rsp_valid !== exp_valid) begin
                bad++;
                $display("FAIL R2 rsp_valid actual=%0b expected=%0b", rsp_valid, exp_valid);
            end
            if (exp_valid) begin
                total++;
                if (rsp_rdata !== exp_data) begin
                    bad++;
                    $display("FAIL %s rsp_rdata actual=%h expected=%h", exp_tag, rsp_rdata, exp_data);
                end
            end
        end
    end

    function automatic logic [31:0] model_read(int r, int ofs);
        case (ofs)
            'h018:   return {m_td[r], 10'b0, 21'(m_occ[r])};
            'h01C:   return 32'(m_widx[r]);
            'h028:   return 32'(m_size[r]);
            default: return 32'h0;
        endcase
    endfunction

    task automatic op(bit v, bit w, int r, int ofs, logic [31:0] d, logic [N-1:0] td, string tag);
        int c;
        @(negedge clk);
        req_valid  = v;
        req_write  = w;
        req_addr   = AW'(r * 'h1000 + ofs);
        req_wdata  = d;
        tdown_done = td;
        pend       = v && !w;
        pend_data  = model_read(r, ofs);
        pend_tag   = tag;
        for (int i = 0; i < N; i++) if (td[i]) m_td[i] = 1;
        if (v && w) begin
            if (ofs == 'h010) begin
                c = d[7] ? int'(d[7:0]) - 256 : int'(d[7:0]);
                m_occ[r] = (m_occ[r] + c + MODV) % MODV;
                if (c > 0 && m_size[r] != 0) m_widx[r] = (m_widx[r] + c) % m_size[r];
            end else if (ofs == 'h028) begin
                m_size[r] = int'(d[IDX_W-1:0]);
            end else if (ofs == 'h02C) begin
                m_occ[r] = 0; m_widx[r] = 0; m_td[r] = 0;
            end
        end
    endtask

    task automatic wr(int r, int ofs, logic [31:0] d);
        op(1, 1, r, ofs, d, '0, "");
    endtask
    task automatic rd(int r, int ofs, string tag);
        op(1, 0, r, ofs, 32'h0, '0, tag);
    endtask
    task automatic idle();
        op(0, 0, 0, 0, 32'h0, '0, "");
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_occ[i] = 0; m_widx[i] = 0; m_size[i] = 0; m_td[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state of every ring
        for (int r = 0; r < N; r++) begin
            rd(r, 'h018, "R1");
            rd(r, 'h01C, "R1");
            rd(r, 'h028, "R1");
        end
        // R11 size register
        wr(0, 'h028, 32'h0001_2345);
        rd(0, 'h028, "R11");
        wr(0, 'h028, 32'd5);
        rd(0, 'h028, "R11");
        // R4 / R6 doorbell pushes
        wr(0, 'h010, 32'h1); wr(0, 'h010, 32'h1); wr(0, 'h010, 32'h1);
        rd(0, 'h018, "R4");
        rd(0, 'h01C, "R6");
        wr(0, 'h010, 32'h3);
        rd(0, 'h01C, "R6");
        wr(0, 'h010, 32'hFF);
        rd(0, 'h018, "R4");
        rd(0, 'h01C, "R6");
        wr(0, 'h010, 32'hABCD_0102);
        rd(0, 'h018, "R4");
        rd(0, 'h01C, "R6");
        wr(0, 'h010, 32'hFFFF_FF00);
        rd(0, 'h018, "R4");
        wr(0, 'h010, 32'h80);
        rd(0, 'h018, "R5");
        wr(0, 'h010, 32'h7F);
        rd(0, 'h018, "R5");
        rd(0, 'h01C, "R6");
        // R5 / R3 wrap on ring 1, R7 isolation
        wr(1, 'h010, 32'hFF);
        rd(1, 'h018, "R5");
        wr(1, 'h010, 32'h5);
        rd(1, 'h018, "R3");
        rd(0, 'h018, "R7");
        rd(2, 'h018, "R7");
        // R8 teardown flag
        op(0, 0, 0, 0, 32'h0, 4'b0100, "");
        rd(2, 'h018, "R8");
        rd(3, 'h018, "R8");
        wr(2, 'h010, 32'h9); wr(2, 'h010, 32'hFE);
        rd(2, 'h018, "R3");
        // R9 clear wins over same-cycle teardown pulse
        op(1, 1, 2, 'h02C, 32'h0, 4'b0100, "");
        rd(2, 'h018, "R9");
        wr(0, 'h02C, 32'hDEAD_BEEF);
        rd(0, 'h018, "R9");
        rd(0, 'h01C, "R9");
        rd(0, 'h028, "R9");
        // R10 unmapped offsets
        wr(3, 'h010, 32'h2);
        wr(3, 'h014, 32'h7); wr(3, 'h020, 32'h7); wr(3, 'h01C, 32'h3);
        wr(3, 'h018, 32'h55); wr(3, 'h500, 32'h1);
        rd(3, 'h018, "R10");
        rd(3, 'h01C, "R10");
        rd(3, 'h010, "R10");
        rd(3, 'h014, "R10");
        rd(3, 'h02C, "R10");
        // R6 size zero keeps index
        wr(3, 'h010, 32'h4);
        rd(3, 'h01C, "R6");
        rd(3, 'h018, "R4");
        // R7 mixed traffic across rings
        for (int k = 0; k < 3000; k++) begin
            int r, s;
            r = int'($urandom_range(N - 1));
            s = int'($urandom_range(9));
            if (s < 4)      wr(r, 'h010, $urandom);
            else if (s == 4) wr(r, 'h028, 32'($urandom_range(12)));
            else if (s == 5) op(0, 0, 0, 0, 32'h0, N'($urandom_range(15)), "");
            else if (s == 6) wr(r, 'h02C, 32'h0);
            else if (s == 7) rd(r, 'h01C, "R7");
            else            rd(r, 'h018, "R7");
        end
        idle(); idle(); idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule